// File: doc/BRIEF.md
# Receive descriptor process controller

This block is the control engine for the receive side of a descriptor-driven Ethernet DMA. After a start command it fetches the current receive descriptor and checks who owns it. If the DMA owns it, the engine waits for a frame. When the frame ends, the engine posts the frame status into the descriptor and hands the descriptor back to the host. It then fetches the next descriptor. If the host owns the descriptor, the engine suspends. It resumes when software issues a poll demand or when the next recognised frame arrives.

Software sees six sticky status flags, which it clears by writing one to them, and a 3-bit process state. Descriptor reads and status writebacks go through a simple request/acknowledge port. Data movement, address filtering and CRC checking belong to other blocks.

Top module: `rx_desc_ctrl`

## Requirements
- R1: After reset, `proc_state` is 3'b000 (Stopped), `status` is all zero, and neither `desc_rd_req` nor `desc_wb_req` is asserted.
- R2: In Stopped, `cmd_start` moves the engine to Fetch (3'b001) with `desc_rd_req` high. A read acknowledge with `desc_rd_own`=1 (DMA-owned) moves it to Running-wait (3'b010).
- R3: A read acknowledge with `desc_rd_own`=0 moves the engine to Suspended (3'b100). It sets buffer-unavailable (`status` bit 1) only if the previous descriptor was DMA-owned. The first fetch after a start counts as following a DMA-owned descriptor.
- R4: In Suspended, `poll_demand` returns the engine to Fetch so the descriptor is read again.
- R5: In Suspended, `frame_start` also returns the engine to Fetch. If the descriptor is then DMA-owned, the engine goes straight to Receiving (3'b111).
- R6: In Receiving, `frame_end` moves the engine to Writeback (3'b101) with `desc_wb_req` high. The writeback word has bit 31 (ownership) zero and the frame length in bits 29:16. `desc_wb_ack` sets receive-complete (`status` bit 0) and returns the engine to Fetch.
- R7: A frame whose `frame_len` exceeds 2048 sets watchdog-timeout (`status` bit 3) and sets bit 4 of the writeback word.
- R8: `overflow` during Receiving sets overflow (`status` bit 4). The partial frame that follows sets bit 11 of its writeback word.
- R9: `bus_err` in any state other than Stopped moves the engine to Stopped. It sets bus-error (`status` bit 5) and process-stopped (`status` bit 2). No descriptor request is made until the next `cmd_start`.
- R10: `cmd_stop` in any state other than Stopped moves the engine to Stopped and sets process-stopped (`status` bit 2).
- R11: Status flags stay set until software clears them. A one in `status_clr` clears that flag one cycle later, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe for the receive process |
| cmd_stop | input | 1 | Stop strobe for the receive process |
| poll_demand | input | 1 | Receive poll demand strobe |
| frame_start | input | 1 | A recognised frame begins |
| frame_end | input | 1 | The current frame ends |
| frame_len | input | 14 | Byte count of the frame, valid with frame_end |
| overflow | input | 1 | Receive buffer overflow during the frame |
| bus_err | input | 1 | Fatal bus error |
| desc_rd_req | output | 1 | Descriptor read request |
| desc_rd_ack | input | 1 | Descriptor read response valid |
| desc_rd_own | input | 1 | Ownership bit of the fetched descriptor (1 = DMA) |
| desc_wb_req | output | 1 | Descriptor status writeback request |
| desc_wb_data | output | 32 | Descriptor status word to write |
| desc_wb_ack | input | 1 | Writeback accepted |
| status_clr | input | 6 | Write-one-to-clear strobes for the status flags |
| status | output | 6 | Sticky status flags |
| proc_state | output | 3 | Encoded process state |

## Verification
Each strobe is applied for one cycle, and the state, requests and status flags it affects are registered. They are sampled on the falling edge after the rising edge that captured the strobe, one cycle after the stimulus. `desc_wb_data` is registered at frame end, so it is valid in that same cycle, together with `desc_wb_req`. A clear through `status_clr` is likewise checked one cycle later. Random frame lengths around the 2048-byte limit and random overflow are compared against a bench function that builds the expected descriptor word.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int LEN_W      = 14;
    localparam int WDOG_LIMIT = 2048;
    localparam int NFLAG      = 6;
    localparam int WB_W       = 32;

    localparam int F_DONE  = 0;
    localparam int F_NOBUF = 1;
    localparam int F_STOP  = 2;
    localparam int F_LONG  = 3;
    localparam int F_OVF   = 4;
    localparam int F_BUS   = 5;

    typedef enum logic [2:0] {
        ST_STOP  = 3'b000,
        ST_FETCH = 3'b001,
        ST_WAIT  = 3'b010,
        ST_SUSP  = 3'b100,
        ST_WB    = 3'b101,
        ST_RECV  = 3'b111
    } rx_state_e;

    typedef struct packed {
        logic             own;
        logic             rsv30;
        logic [LEN_W-1:0] len;
        logic [3:0]       rsv15;
        logic             ovf;
        logic [5:0]       rsv10;
        logic             too_long;
        logic [3:0]       rsv3;
    } desc_word_t;

    function automatic desc_word_t make_desc(input logic [LEN_W-1:0] len,
                                             input logic ovf);
        desc_word_t d;
        d          = '0;
        d.own      = 1'b0;
        d.len      = len;
        d.ovf      = ovf;
        d.too_long = (len > LEN_W'(WDOG_LIMIT));
        return d;
    endfunction
endpackage

// File: rtl/rxd_status.sv
module rxd_status
    import rxd_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_o[i] <= 1'b0;
            else if (set_i[i])
                flags_o[i] <= 1'b1;
            else if (clr_i[i])
                flags_o[i] <= 1'b0;
        end
    end

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             poll_demand,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             overflow,
    input  logic             bus_err,
    input  logic             rd_ack,
    input  logic             rd_own,
    input  logic             wb_ack,
    output logic             rd_req,
    output logic             wb_req,
    output logic [WB_W-1:0]  wb_word,
    output rx_state_e        state,
    output logic [NFLAG-1:0] set_vec
);
    logic       prev_dma;
    logic       frame_pend;
    logic       ovf_seen;
    desc_word_t wb_q;
    logic       active;
    logic       halt;
    logic       go;

    assign active  = (state != ST_STOP);
    assign halt    = active && (bus_err || cmd_stop);
    assign go      = active && !halt;
    assign rd_req  = (state == ST_FETCH);
    assign wb_req  = (state == ST_WB);
    assign wb_word = wb_q;

    always_comb begin
        set_vec          = '0;
        set_vec[F_BUS]   = active && bus_err;
        set_vec[F_STOP]  = halt;
        set_vec[F_NOBUF] = go && state == ST_FETCH && rd_ack && !rd_own && prev_dma;
        set_vec[F_DONE]  = go && state == ST_WB && wb_ack;
        set_vec[F_LONG]  = go && state == ST_RECV && frame_end &&
                           (frame_len > LEN_W'(WDOG_LIMIT));
        set_vec[F_OVF]   = go && state == ST_RECV && overflow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_STOP;
            prev_dma   <= 1'b1;
            frame_pend <= 1'b0;
            ovf_seen   <= 1'b0;
            wb_q       <= '0;
        end else if (halt) begin
            state      <= ST_STOP;
            frame_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_STOP: if (cmd_start) begin
                    state      <= ST_FETCH;
                    prev_dma   <= 1'b1;
                    frame_pend <= 1'b0;
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        frame_pend <= 1'b0;
                        ovf_seen   <= 1'b0;
                        prev_dma   <= rd_own;
                        if (!rd_own)
                            state <= ST_SUSP;
                        else if (frame_pend || frame_start)
                            state <= ST_RECV;
                        else
                            state <= ST_WAIT;
                    end else if (frame_start) begin
                        frame_pend <= 1'b1;
                    end
                end
                ST_WAIT: if (frame_start) begin
                    state    <= ST_RECV;
                    ovf_seen <= 1'b0;
                end
                ST_RECV: begin
                    if (overflow)
                        ovf_seen <= 1'b1;
                    if (frame_end) begin
                        state <= ST_WB;
                        wb_q  <= make_desc(frame_len, ovf_seen || overflow);
                    end
                end
                ST_WB: if (wb_ack) state <= ST_FETCH;
                ST_SUSP: begin
                    if (poll_demand || frame_start) begin
                        state      <= ST_FETCH;
                        frame_pend <= frame_start;
                    end
                end
                default: state <= ST_STOP;
            endcase
        end
    end

    assert_stop_enter_R10: assert property (@(posedge clk) disable iff (rst)
        (active && cmd_stop) |=> (state == ST_STOP));
    assert_bus_halt_R9: assert property (@(posedge clk) disable iff (rst)
        (active && bus_err) |=> (state == ST_STOP && !rd_req && !wb_req));
    assert_suspend_R3: assert property (@(posedge clk) disable iff (rst)
        (go && state == ST_FETCH && rd_ack && !rd_own) |=> (state == ST_SUSP));
    assert_frame_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (go && state == ST_RECV && frame_end) |=> (wb_req && !wb_word[31]));
    assert_start_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && cmd_start) |=> rd_req);
endmodule

// File: rtl/rx_desc_ctrl.sv
module rx_desc_ctrl
    import rxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             poll_demand,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             overflow,
    input  logic             bus_err,
    output logic             desc_rd_req,
    input  logic             desc_rd_ack,
    input  logic             desc_rd_own,
    output logic             desc_wb_req,
    output logic [WB_W-1:0]  desc_wb_data,
    input  logic             desc_wb_ack,
    input  logic [NFLAG-1:0] status_clr,
    output logic [NFLAG-1:0] status,
    output logic [2:0]       proc_state
);
    rx_state_e        st;
    logic [NFLAG-1:0] set_vec;

    rxd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .poll_demand (poll_demand),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_len   (frame_len),
        .overflow    (overflow),
        .bus_err     (bus_err),
        .rd_ack      (desc_rd_ack),
        .rd_own      (desc_rd_own),
        .wb_ack      (desc_wb_ack),
        .rd_req      (desc_rd_req),
        .wb_req      (desc_wb_req),
        .wb_word     (desc_wb_data),
        .state       (st),
        .set_vec     (set_vec)
    );

    rxd_status #(.N(NFLAG)) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (status_clr),
        .flags_o (status)
    );

    assign proc_state = st;

    assert_nobuf_in_susp_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(status[F_NOBUF]) |-> (proc_state == 3'b100));
    assert_done_after_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (desc_wb_req && desc_wb_ack && !bus_err && !cmd_stop) |=> status[F_DONE]);
endmodule

// File: tb/tb_rx_desc_ctrl.sv
module tb_rx_desc_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 0, cmd_stop = 0, poll_demand = 0;
    logic        frame_start = 0, frame_end = 0, overflow = 0, bus_err = 0;
    logic [13:0] frame_len = '0;
    logic        desc_rd_ack = 0, desc_rd_own = 0, desc_wb_ack = 0;
    logic [5:0]  status_clr = '0;
    logic        desc_rd_req, desc_wb_req;
    logic [31:0] desc_wb_data;
    logic [5:0]  status;
    logic [2:0]  proc_state;

    int checks = 0;
    int errors = 0;

    rx_desc_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_desc(input logic [13:0] len, input logic ovf);
        logic [31:0] w;
        w        = '0;
        w[29:16] = len;
        w[11]    = ovf;
        w[4]     = (len > 14'd2048);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic clear_all;
        status_clr = 6'h3f; tick; status_clr = '0;
    endtask

    task automatic pulse_start;  cmd_start = 1; tick; cmd_start = 0; endtask
    task automatic pulse_stop;   cmd_stop = 1; tick; cmd_stop = 0; endtask
    task automatic pulse_poll;   poll_demand = 1; tick; poll_demand = 0; endtask
    task automatic pulse_frame;  frame_start = 1; tick; frame_start = 0; endtask
    task automatic pulse_ovf;    overflow = 1; tick; overflow = 0; endtask
    task automatic pulse_buserr; bus_err = 1; tick; bus_err = 0; endtask

    task automatic answer_fetch(input logic own);
        desc_rd_ack = 1; desc_rd_own = own; tick; desc_rd_ack = 0; desc_rd_own = 0;
    endtask

    task automatic end_frame(input logic [13:0] len);
        frame_end = 1; frame_len = len; tick; frame_end = 0; frame_len = '0;
    endtask

    task automatic accept_wb;
        desc_wb_ack = 1; tick; desc_wb_ack = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick;
        rst = 0;
        tick;
        chk("R1 state", proc_state, 3'b000);
        chk("R1 status", status, 6'h00);
        chk("R1 req", {desc_rd_req, desc_wb_req}, 2'b00);

        pulse_start;
        chk("R2 fetch", proc_state, 3'b001);
        chk("R2 rd_req", desc_rd_req, 1'b1);
        answer_fetch(1'b1);
        chk("R2 running", proc_state, 3'b010);

        pulse_frame;
        chk("R6 recv", proc_state, 3'b111);
        end_frame(14'd100);
        chk("R6 writeback", proc_state, 3'b101);
        chk("R6 wb_req", desc_wb_req, 1'b1);
        chk("R6 word", desc_wb_data, exp_desc(14'd100, 1'b0));
        chk("R6 no flag yet", status, 6'h00);
        accept_wb;
        chk("R6 done flag", status, 6'h01);
        chk("R6 refetch", proc_state, 3'b001);

        answer_fetch(1'b0);
        chk("R3 suspended", proc_state, 3'b100);
        chk("R3 nobuf set", status, 6'h03);
        status_clr = 6'h02; tick; status_clr = '0;
        chk("R11 clear one", status, 6'h01);
        tick;
        chk("R11 sticky", status, 6'h01);

        pulse_poll;
        chk("R4 refetch", proc_state, 3'b001);
        answer_fetch(1'b0);
        chk("R3 resuspend", proc_state, 3'b100);
        chk("R3 no reflag", status, 6'h01);

        pulse_frame;
        chk("R5 refetch", proc_state, 3'b001);
        answer_fetch(1'b1);
        chk("R5 straight recv", proc_state, 3'b111);
        end_frame(14'd3000);
        chk("R7 long word", desc_wb_data, exp_desc(14'd3000, 1'b0));
        chk("R7 long flag", status, 6'h09);
        accept_wb;
        clear_all;
        chk("R11 clear all", status, 6'h00);

        answer_fetch(1'b1);
        pulse_frame;
        pulse_ovf;
        chk("R8 ovf flag", status, 6'h10);
        end_frame(14'd2048);
        chk("R8 ovf word", desc_wb_data, exp_desc(14'd2048, 1'b1));
        chk("R7 2048 not long", status[3], 1'b0);
        accept_wb;

        pulse_stop;
        chk("R10 stopped", proc_state, 3'b000);
        chk("R10 flag", status[2], 1'b1);
        clear_all;
        pulse_stop;
        chk("R10 stop when stopped", status, 6'h00);

        pulse_start;
        pulse_buserr;
        chk("R9 stopped", proc_state, 3'b000);
        chk("R9 flags", status, 6'h24);
        chk("R9 no req", {desc_rd_req, desc_wb_req}, 2'b00);
        answer_fetch(1'b1);
        chk("R9 ignores ack", proc_state, 3'b000);
        clear_all;
        pulse_start;
        chk("R9 restart", desc_rd_req, 1'b1);

        for (int i = 0; i < 40; i++) begin
            logic [13:0] len;
            logic        ovf;
            logic        host;
            len  = 14'($urandom_range(1, 4000));
            ovf  = ($urandom_range(0, 3) == 0);
            host = ($urandom_range(0, 2) == 0);
            if (host) begin
                answer_fetch(1'b0);
                chk("R3 rand susp", proc_state, 3'b100);
                pulse_poll;
            end
            answer_fetch(1'b1);
            pulse_frame;
            if (ovf) pulse_ovf;
            end_frame(len);
            chk("R6 rand word", desc_wb_data, exp_desc(len, ovf));
            chk("R7 rand flags", status[4:3], {ovf, len > 14'd2048});
            accept_wb;
            chk("R6 rand done", status[0], 1'b1);
            clear_all;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule